// File: doc/BRIEF.md
# Gate-Qualified Event Counter

This block is an up-counter that advances on the core clock only while a qualified gate signal is active. An external gate pin is brought into the clock domain through a synchroniser and can be inverted. It is then shaped by one of four gate modes: plain level, toggle (each active rising edge flips the qualifier), single-shot (one active gate window after software arms it), or toggle and single-shot together. The last mode captures exactly one full gate period. When gating is switched off, the counter runs freely.

The qualified gate level is always readable as a status output. A falling edge of that level sets an event flag, and the flag drives an interrupt request when the interrupt is enabled. Both the status and the flag keep working when gating is switched off. The whole configuration is loaded with one write strobe. The event flag is cleared by a separate clear strobe.

Top module: `gated_ctr`

## Requirements
- R1: After reset, `count`, `gate_val`, `armed`, `evt_flag` and `irq` are all 0.
- R2: With the enable field (`ctl_wdata[0]`) at 0, `count` increments on every clock and wraps modulo 2^CNT_W.
- R3: With enable at 1 and all mode fields at 0, `count` grows by exactly the number of clock cycles for which `gate_in` was held high.
- R4: The invert field (`ctl_wdata[1]`) inverts the gate before all other logic, so `count` grows by the number of cycles `gate_in` was held low.
- R5: In toggle mode (`ctl_wdata[2]`), the qualified gate flips on each active rising edge of the gate. Two gate pulses spaced P cycles apart add exactly P to `count`, and `gate_val` is 1 between those two edges.
- R6: In single-shot mode (`ctl_wdata[3]`), writing the arm field (`ctl_wdata[4]`) as 1 sets `armed`. Counting starts on the next active rising edge of the gate and lasts for that one active window only. `armed` returns to 0 when that window ends, and later pulses do not count. A gate that is already active when the block is armed does not start a window.
- R7: In toggle and single-shot mode together, counting covers exactly one full gate period, from one active rising edge to the next, and then `armed` returns to 0.
- R8: `gate_val` follows the qualified gate, and each falling edge of `gate_val` sets `evt_flag`, even with enable at 0.
- R9: `evt_flag` stays set until a `flag_clr` pulse clears it. `irq` is 1 exactly when `evt_flag` and the interrupt-enable field (`ctl_wdata[5]`) are both 1.
- R10: A write with the arm field at 1 while the single-shot field is 0 leaves `armed` at 0 and does not change counting. Any write with the single-shot field at 0 also leaves `armed` at 0.
- R11: With enable at 1, `count` holds its value while `gate_val` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the count clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_in | input | 1 | Asynchronous gate pin |
| ctl_we | input | 1 | Loads `ctl_wdata` into the configuration |
| ctl_wdata | input | 6 | {irq_en, arm, single, toggle, invert, enable} |
| flag_clr | input | 1 | Clears the gate event flag |
| count | output | CNT_W | Counter value |
| gate_val | output | 1 | Qualified gate level |
| armed | output | 1 | Single-shot arm bit, cleared by hardware when the window ends |
| evt_flag | output | 1 | Gate event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W = 8 and the default two-stage synchroniser. The narrow counter makes wrap-around reachable within a few hundred cycles. Pulse widths and gate periods are swept over small ranges in every mode, and each expected count is simply the swept width or period. This works because the fixed latency through the synchroniser and the mode logic cancels out of every measured difference.

// File: rtl/gc_pkg.sv
package gc_pkg;
   typedef struct packed {
      logic ien;
      logic arm;
      logic single;
      logic toggle;
      logic invert;
      logic enable;
   } gc_cfg_t;

   localparam int GC_CFG_W = $bits(gc_cfg_t);
endpackage

// File: rtl/gc_sync.sv
module gc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $fatal(1, "gc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gc_gate.sv
module gc_gate #(
   parameter bit TOGGLE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic g_sync,
   input  logic invert,
   input  logic toggle,
   input  logic single,
   input  logic arm,
   output logic gv,
   output logic gv_fall
);
   logic g_pol, pol_d, pol_rise;
   logic base, base_d, base_rise;
   logic gv_n;

   assign g_pol    = g_sync ^ invert;
   assign pol_rise = g_pol & ~pol_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pol_d <= 1'b0;
      else        pol_d <= g_pol;

   generate
      if (TOGGLE_EN) begin : g_tgl
         logic tq;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)        tq <= 1'b0;
            else if (!toggle)  tq <= 1'b0;
            else if (pol_rise) tq <= ~tq;
         assign base = toggle ? tq : g_pol;
      end else begin : g_lvl
         logic unused_tgl;
         assign unused_tgl = toggle ^ pol_rise;
         assign base = g_pol;
      end
   endgenerate

   assign base_rise = base & ~base_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) base_d <= 1'b0;
      else        base_d <= base;

   always_comb begin
      if (single) gv_n = arm & base & (gv | base_rise);
      else        gv_n = base;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) gv <= 1'b0;
      else        gv <= gv_n;

   assign gv_fall = gv & ~gv_n;
endmodule

// File: rtl/gc_count.sv
module gc_count #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   initial begin
      if (W < 2) $fatal(1, "gc_count: W must be at least 2");
   end

   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + ONE;
endmodule

// File: rtl/gated_ctr.sv
module gated_ctr
   import gc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit TOGGLE_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gate_in,
   input  logic                ctl_we,
   input  logic [GC_CFG_W-1:0] ctl_wdata,
   input  logic                flag_clr,
   output logic [CNT_W-1:0]    count,
   output logic                gate_val,
   output logic                armed,
   output logic                evt_flag,
   output logic                irq
);
   gc_cfg_t cfg_q, cfg_w;
   logic    arm_q, flag_q;
   logic    g_sync, gv, gv_fall;

   assign cfg_w = gc_cfg_t'(ctl_wdata);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cfg_q <= '0;
      else if (ctl_we) cfg_q <= cfg_w;

   // arm bit: software write wins; hardware clears it when a window closes
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        arm_q <= 1'b0;
      else if (ctl_we)                   arm_q <= cfg_w.arm & cfg_w.single;
      else if (gv_fall && cfg_q.single)  arm_q <= 1'b0;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        flag_q <= 1'b0;
      else if (gv_fall)  flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;

   gc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(gate_in), .q(g_sync)
   );

   gc_gate #(.TOGGLE_EN(TOGGLE_EN)) u_gate (
      .clk(clk), .rst_n(rst_n), .g_sync(g_sync),
      .invert(cfg_q.invert), .toggle(cfg_q.toggle), .single(cfg_q.single),
      .arm(arm_q), .gv(gv), .gv_fall(gv_fall)
   );

   gc_count #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(~cfg_q.enable | gv), .cnt(count)
   );

   assign gate_val = gv;
   assign armed    = arm_q;
   assign evt_flag = flag_q;
   assign irq      = flag_q & cfg_q.ien;
endmodule

// File: rtl/gc_chk.sv
module gc_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en,
   input logic         single,
   input logic         ctl_we,
   input logic         arm,
   input logic         gv,
   input logic         flag,
   input logic         flag_clr,
   input logic         irq,
   input logic [W-1:0] cnt
);
   // R2
   free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt == W'($past(cnt) + 1'b1));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !gv) |=> $stable(cnt));

   // R8
   fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gv) |-> flag);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);

   // R9
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag |-> !irq);

   // R10
   arm_needs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !single |-> !arm);

   // R6
   arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gv) && $past(single) && !$past(ctl_we)) |-> !arm);
endmodule

bind gated_ctr gc_chk #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(cfg_q.enable), .single(cfg_q.single),
   .ctl_we(ctl_we), .arm(arm_q), .gv(gv), .flag(flag_q),
   .flag_clr(flag_clr), .irq(irq), .cnt(count)
);

// File: tb/tb_gated_ctr.sv
`timescale 1ns/1ps
module tb_gated_ctr;
   localparam int W = 8;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         gate_in = 1'b0;
   logic         ctl_we = 1'b0;
   logic [5:0]   ctl_wdata = '0;
   logic         flag_clr = 1'b0;
   logic [W-1:0] count;
   logic         gate_val, armed, evt_flag, irq;

   int  nchk = 0;
   int  nfail = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   gated_ctr #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .ctl_we(ctl_we),
      .ctl_wdata(ctl_wdata), .flag_clr(flag_clr), .count(count),
      .gate_val(gate_val), .armed(armed), .evt_flag(evt_flag), .irq(irq)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // fields: {ien, arm, single, toggle, invert, enable}
   task automatic wr(input bit en, input bit inv, input bit tgl,
                     input bit sgl, input bit arm, input bit ien);
      ctl_wdata = {ien, arm, sgl, tgl, inv, en};
      ctl_we = 1'b1;
      tick(1);
      ctl_we = 1'b0;
   endtask

   task automatic clr();
      flag_clr = 1'b1;
      tick(1);
      flag_clr = 1'b0;
   endtask

   task automatic pulse(input bit act, input int h, input int l);
      gate_in = act;
      tick(h);
      gate_in = ~act;
      tick(l);
   endtask

   function automatic int delta(input int c0);
      return (int'(count) - c0 + M) % M;
   endfunction

   initial begin
      int c0;
      tick(3);
      // R1
      chk("R1 count", int'(count), 0);
      chk("R1 gate_val", int'(gate_val), 0);
      chk("R1 armed", int'(armed), 0);
      chk("R1 evt_flag", int'(evt_flag), 0);
      chk("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      tick(2);

      // R2 free run with wrap
      wr(0,0,0,0,0,0);
      c0 = int'(count);
      tick(300);
      chk("R2 wrap", delta(c0), 300 % M);

      // R3 level sweep, R11 hold
      wr(1,0,0,0,0,0);
      tick(6);
      for (int h = 1; h <= 16; h++) begin
         c0 = int'(count);
         pulse(1'b1, h, 8);
         chk("R3 level", delta(c0), h);
         c0 = int'(count);
         tick(10);
         chk("R11 hold", delta(c0), 0);
      end

      // R4 inverted
      gate_in = 1'b1;
      wr(1,1,0,0,0,0);
      tick(8);
      for (int h = 1; h <= 8; h++) begin
         c0 = int'(count);
         pulse(1'b0, h, 8);
         chk("R4 invert", delta(c0), h);
      end
      gate_in = 1'b0;
      wr(1,0,0,0,0,0);
      tick(8);

      // R5 toggle
      wr(1,0,1,0,0,0);
      tick(6);
      for (int p = 4; p <= 12; p++) begin
         c0 = int'(count);
         pulse(1'b1, 2, p - 2);
         chk("R5 gate_val mid", int'(gate_val), 1);
         pulse(1'b1, 2, 10);
         chk("R5 gate_val end", int'(gate_val), 0);
         chk("R5 period", delta(c0), p);
      end

      // R6 single-shot
      wr(1,0,0,0,0,0);
      tick(4);
      for (int h = 1; h <= 6; h++) begin
         wr(1,0,0,1,1,0);
         clr();
         tick(3);
         chk("R6 armed set", int'(armed), 1);
         c0 = int'(count);
         pulse(1'b1, h, 8);
         chk("R6 one window", delta(c0), h);
         chk("R6 armed cleared", int'(armed), 0);
         chk("R6 flag", int'(evt_flag), 1);
         pulse(1'b1, h + 2, 8);
         chk("R6 later pulse ignored", delta(c0), h);
      end
      // R6 armed while gate already high
      gate_in = 1'b1;
      tick(6);
      wr(1,0,0,1,1,0);
      c0 = int'(count);
      tick(5);
      gate_in = 1'b0;
      tick(8);
      chk("R6 no start on high level", delta(c0), 0);
      pulse(1'b1, 4, 8);
      chk("R6 next rising edge", delta(c0), 4);

      // R7 toggle + single-shot
      for (int p = 4; p <= 10; p++) begin
         wr(1,0,0,0,0,0);
         tick(2);
         wr(1,0,1,1,1,0);
         tick(3);
         c0 = int'(count);
         pulse(1'b1, 2, p - 2);
         pulse(1'b1, 2, p - 2);
         pulse(1'b1, 2, 8);
         tick(6);
         chk("R7 one period", delta(c0), p);
         chk("R7 armed cleared", int'(armed), 0);
      end

      // R10 arm without single-shot
      wr(1,0,0,0,1,0);
      tick(4);
      chk("R10 armed stays 0", int'(armed), 0);
      c0 = int'(count);
      pulse(1'b1, 5, 8);
      chk("R10 level counting unchanged", delta(c0), 5);

      // R8 status and flag with gating off
      wr(0,0,0,0,0,0);
      clr();
      tick(2);
      chk("R8 flag cleared", int'(evt_flag), 0);
      c0 = int'(count);
      gate_in = 1'b1;
      tick(4);
      chk("R8 gate_val high", int'(gate_val), 1);
      gate_in = 1'b0;
      tick(4);
      chk("R8 gate_val low", int'(gate_val), 0);
      chk("R8 flag on fall", int'(evt_flag), 1);
      chk("R8 free count", delta(c0), 8);

      // R9 flag and irq
      chk("R9 irq masked", int'(irq), 0);
      wr(0,0,0,0,0,1);
      tick(1);
      chk("R9 irq raised", int'(irq), 1);
      tick(20);
      chk("R9 flag sticky", int'(evt_flag), 1);
      clr();
      tick(1);
      chk("R9 flag cleared", int'(evt_flag), 0);
      chk("R9 irq dropped", int'(irq), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule